// File: doc/BRIEF.md
# Load-Adaptive Dead-Time Inserter

This block sits between a PWM generator and the gate drivers of one half-bridge leg. It takes a single raw drive level, where high means the upper switch should conduct and low means the lower one should. From it, it produces two gate commands. A turn-off follows the raw drive within one clock. A turn-on waits until a dead interval has passed with both gates low.

The length of that interval depends on the load. A digitised current-sense code and an adaptive setpoint code set a control level. The dead time is a per-leg scale divided by that level, plus a fixed offset. When the setpoint is zero, the dead time falls over a 4:1 span as the sensed current rises from zero to the peak threshold. When the setpoint equals the sensed current, the dead time stays at its longest value.

A full bridge uses two instances, one per leg. Each has its own scale, because the two legs need different resonant transition times. A bypass input removes the inserted dead time for a leg.

Top module: `deadtime_leg`

## Requirements
- R1: While reset is asserted, both gates are low. After reset, the first gate turns on only after a full dead interval computed from the present inputs.
- R2: `gate_hi` and `gate_lo` are never high in the same cycle.
- R3: When `drv_in` changes outside bypass, the gate that was on goes low after the first clock edge.
- R4: The control level, in code units, is OFS + floor(3·(cs_code − set_code)/4), where OFS = PEAK_CODE/4. A code of PEAK_CODE stands for the peak-current threshold. With the defaults PEAK_CODE = 128, so OFS = 32.
- R5: When `set_code` ≥ `cs_code`, the difference is taken as zero. The level then clamps to OFS and the dead interval is scale + FIX_CYC cycles.
- R6: The dead interval is D = floor(scale·OFS/level) + FIX_CYC clock cycles (default FIX_CYC = 2). Both gates stay low for exactly D cycles before the new gate turns on.
- R7: When `set_code` is 0, the scaled part of D drops from `scale` at `cs_code` = 0 to scale/4 at `cs_code` = PEAK_CODE, a 4:1 range.
- R8: D is computed from the inputs present in the cycle the interval starts. Changes to `cs_code`, `set_code` or `scale` during the interval do not alter its length.
- R9: If `drv_in` changes again during a dead interval, the interval still runs its full length. The gate that then turns on is the one selected by `drv_in` at expiry.
- R10: While `bypass` is high, `gate_hi` follows `drv_in` and `gate_lo` follows its inverse, one clock later, with no dead interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_in | input | 1 | Raw leg drive: 1 selects the upper gate, 0 selects the lower gate |
| bypass | input | 1 | 1 removes the dead time; the gates follow drv_in |
| cs_code | input | CW | Digitised load-current code |
| set_code | input | CW | Adaptive setpoint code |
| scale | input | SW | Per-leg dead-time scale, in cycles at the lightest load |
| gate_hi | output | 1 | Upper gate command |
| gate_lo | output | 1 | Lower gate command |

## Verification
The assertions check on every cycle that the two gates are never both high and that an on gate drops one edge after the drive turns away. They also check that every non-bypassed turn-on follows at least FIX_CYC cycles with both gates low, matches the drive level, and that bypass mirrors the drive. Only the bench scenarios can show the exact interval length for each current and setpoint pair: the clamp when the setpoint is above the current, the 4:1 span, and the freezing of the length against mid-interval code changes and drive reversals.

// File: rtl/deadtime_leg.sv
module deadtime_leg #(
  parameter int CW        = 8,
  parameter int SW        = 8,
  parameter int PEAK_CODE = 128,
  parameter int FIX_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_in,
  input  logic          bypass,
  input  logic [CW-1:0] cs_code,
  input  logic [CW-1:0] set_code,
  input  logic [SW-1:0] scale,
  output logic          gate_hi,
  output logic          gate_lo
);
  localparam int OFS = PEAK_CODE / 4;
  localparam int LW  = CW + 2;
  localparam int PW  = SW + LW;
  localparam int DW  = SW + $clog2(FIX_CYC + 2) + 1;

  logic [CW-1:0] diff;
  logic [CW+1:0] diff3;
  logic [LW-1:0] level;
  logic [PW-1:0] quot;
  logic [DW-1:0] dead;
  logic [DW-1:0] cnt;
  logic          busy;

  assign diff  = (cs_code > set_code) ? cs_code - set_code : '0;
  assign diff3 = {2'b00, diff} + {1'b0, diff, 1'b0};
  assign level = LW'(OFS) + LW'(diff3 >> 2);
  assign quot  = (PW'(scale) * PW'(OFS)) / PW'(level);
  assign dead  = DW'(quot) + DW'(FIX_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (bypass) begin
      gate_hi <= drv_in;
      gate_lo <= !drv_in;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (busy) begin
      if (cnt <= DW'(1)) begin
        gate_hi <= drv_in;
        gate_lo <= !drv_in;
        busy    <= 1'b0;
      end else begin
        cnt <= cnt - DW'(1);
      end
    end else if (gate_hi != drv_in || gate_lo != !drv_in) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      busy    <= 1'b1;
      cnt     <= dead;
    end
  end
endmodule

module deadtime_leg_chk #(
  parameter int FIX_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic drv_in,
  input logic bypass,
  input logic gate_hi,
  input logic gate_lo
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!gate_hi && !gate_lo) low_run <= (low_run == 16'hffff) ? low_run : low_run + 16'd1;
    else low_run <= '0;
  end

  a_r2_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r3_hi_off_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && !drv_in && !bypass) |=> !gate_hi);

  a_r3_lo_off_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && drv_in && !bypass) |=> !gate_lo);

  a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(gate_hi) || $rose(gate_lo)) && !$past(bypass)) |-> (low_run >= 16'(FIX_CYC)));

  a_r9_on_matches_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && !$past(bypass)) |-> $past(drv_in));

  a_r10_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (gate_hi == $past(drv_in)) && (gate_lo == !$past(drv_in)));
endmodule

bind deadtime_leg deadtime_leg_chk #(.FIX_CYC(FIX_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_in(drv_in), .bypass(bypass),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/deadtime_leg_test.sv
module deadtime_leg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv = 1'b0;
  logic       byp = 1'b0;
  logic [7:0] cs = 8'd0;
  logic [7:0] sp = 8'd0;
  logic [7:0] sc = 8'd40;
  logic       hi, lo;

  int checks = 0;
  int fails = 0;
  int both_high = 0;
  bit done = 0;

  always #10 clk = ~clk;

  deadtime_leg uut (
    .clk(clk), .rst_n(rst_n), .drv_in(drv), .bypass(byp),
    .cs_code(cs), .set_code(sp), .scale(sc),
    .gate_hi(hi), .gate_lo(lo)
  );

  localparam int NV = 8;
  localparam int V_CS [NV] = '{0,   128, 64, 100, 50, 128, 0, 255};
  localparam int V_SP [NV] = '{0,   0,   0,  100, 90, 64,  0, 0};
  localparam int V_SC [NV] = '{40,  40,  40, 40,  40, 80,  0, 255};
  localparam int V_D  [NV] = '{42,  12,  18, 42,  42, 34,  2, 38};

  always @(negedge clk) if (hi && lo) both_high++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int gap);
    gap = 0;
    forever begin
      @(negedge clk);
      if (!hi && !lo && gap < 5000) gap++;
      else break;
    end
  endtask

  initial begin
    int g, g2;
    repeat (3) @(negedge clk);
    check("R1 reset both low", {hi, lo}, 0);
    rst_n = 1'b1;
    measure(g);
    check("R1 first gap after reset", g, 42);
    check("R1 lower gate on", {hi, lo}, 1);

    for (int i = 0; i < NV; i++) begin
      cs = 8'(V_CS[i]); sp = 8'(V_SP[i]); sc = 8'(V_SC[i]);
      drv = ~drv;
      measure(g);
      check("R4 R5 R6 R7 gap length", g, V_D[i]);
      check("R6 new gate matches drive", {hi, lo}, {drv, !drv});
    end

    cs = 0; sp = 0; sc = 40;
    repeat (3) @(negedge clk);
    drv = ~drv;
    @(negedge clk);
    check("R3 on gate off after one edge", {hi, lo}, 0);
    repeat (4) @(negedge clk);
    cs = 128; sc = 0;
    measure(g2);
    check("R8 length frozen", 5 + g2, 42);
    sc = 40; cs = 0;

    repeat (3) @(negedge clk);
    drv = ~drv;
    repeat (3) @(negedge clk);
    drv = ~drv;
    measure(g2);
    check("R9 full gap on reversal", 3 + g2, 42);
    check("R9 gate at expiry follows drive", {hi, lo}, {drv, !drv});

    byp = 1'b1;
    drv = ~drv;
    @(negedge clk);
    check("R10 bypass follows drive", {hi, lo}, {drv, !drv});
    drv = ~drv;
    @(negedge clk);
    check("R10 bypass follows again", {hi, lo}, {drv, !drv});
    byp = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 leaving bypass keeps state", {hi, lo}, {drv, !drv});

    check("R2 both gates never high", both_high, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule